// File: doc/BRIEF.md
# Non-Maskable Interrupt Latch and Interrupt Vector Unit

This block decides, at each instruction boundary, whether the processor core takes an interrupt. If it does, it reports which interrupt type is taken and the byte address of that type's entry in the interrupt vector table. There are two sources.

- The non-maskable pin is asynchronous. It is synchronised, then qualified: it must be seen high for a minimum number of clocks before its rising edge counts. A qualified edge is held until an instruction boundary serves it. A served NMI always uses type 2. It is armed again only by an edge that arrives once the handler has started.
- The maskable request is a level input. It is honoured only while the interrupt-enable flag is set. Its type is the 8-bit number that the requesting device drives during the acknowledge.

The core pulses `boundary` at every instruction end, and also between element moves of block instructions. It pulses `handler_start` when the service routine begins. The acknowledge bus cycles and the stack push are handled elsewhere.

Three state machines make up the block:

- **Edge qualifier**
  - States: `DET_LOW`, `DET_ARM`, `DET_HIGH`.
  - `LOW→ARM` when the synchronised level goes high.
  - `ARM→LOW` when the level drops early. This rejects a glitch.
  - `ARM→HIGH` once the level has been high for the minimum time. This transition emits one rise pulse.
  - `HIGH→LOW` on the falling level.
- **NMI latch**
  - States: `NL_IDLE`, `NL_PEND`, `NL_SERV`.
  - `IDLE→PEND` on a rise.
  - `PEND→SERV` on the arbiter's NMI grant.
  - `SERV→IDLE` on `handler_start`.
  - `SERV→PEND` on `handler_start` together with a rise.
  - A rise in `PEND` is merged into the pending request. A rise in `SERV` before `handler_start` is dropped.
- **Arbiter**
  - States: `AR_RUN`, `AR_BUSY`.
  - `RUN→BUSY` when an interrupt is taken at a boundary.
  - `BUSY→RUN` on `handler_start`.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `take`, `take_nmi` and `nmi_pending` are low and stay low until some stimulus arrives.
- R2: A rising edge on `nmi_pin` that stays high for at least MIN_HIGH clocks (3 by default) sets `nmi_pending` within SYNC_STAGES+MIN_HIGH+1 clocks.
- R3: A high pulse on `nmi_pin` shorter than MIN_HIGH clocks (1 or 2 clocks by default) never sets `nmi_pending`.
- R4: Holding `nmi_pin` high produces exactly one NMI. Its falling edge creates no request.
- R5: When an NMI is pending and `boundary` is high in the arbiter's run state, the next cycle carries a single-cycle `take` with `take_nmi`=1 and `take_type`=8'h02. With no boundary, the NMI stays pending.
- R6: If an NMI is pending and a maskable request is valid on the same boundary, the NMI is taken. The maskable request is taken at a later boundary.
- R7: A maskable request is taken only when `intr_req` and `int_enable` are both 1 at the boundary. `take_type` is then the value of `dev_type` at that boundary and `take_nmi` is 0.
- R8: `take_vec` equals `take_type` times 4. It is a 10-bit byte address from 000h to 3FCh.
- R9: After a `take`, further boundaries produce no `take` until `handler_start` has been pulsed.
- R10: A second qualified NMI edge that arrives while an NMI is still pending is merged into it, so only one NMI is taken.
- R11: A qualified NMI edge that arrives after an NMI is taken but before `handler_start` is dropped. An edge that arrives after `handler_start` produces a new pending NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_pin | input | 1 | Asynchronous non-maskable request pin |
| intr_req | input | 1 | Maskable request level |
| int_enable | input | 1 | Interrupt-enable flag; gates `intr_req` only |
| boundary | input | 1 | Instruction-boundary strobe |
| handler_start | input | 1 | Pulse when the service routine begins |
| dev_type | input | TYPE_W | Type number supplied by the device |
| take | output | 1 | One-cycle pulse: interrupt taken |
| take_nmi | output | 1 | The taken interrupt is the NMI |
| take_type | output | TYPE_W | Type of the taken interrupt |
| take_vec | output | TYPE_W+2 | Vector table byte address (type × 4) |
| nmi_pending | output | 1 | An NMI is latched and not yet taken |

## Verification
The bench uses the defaults: SYNC_STAGES=2, MIN_HIGH=3 and TYPE_W=8. With MIN_HIGH=3, a 2-clock pulse is the longest that must be rejected and a 3-clock pulse is the shortest that must be accepted, so the qualification threshold is tested on both sides. With TYPE_W=8, the vector table covers types 00h to FFh, and the bench checks the extreme addresses 000h and 3FCh.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        DET_LOW,
        DET_ARM,
        DET_HIGH
    } det_state_e;

    typedef enum logic [1:0] {
        NL_IDLE,
        NL_PEND,
        NL_SERV
    } nl_state_e;

    typedef enum logic {
        AR_RUN,
        AR_BUSY
    } ar_state_e;

    localparam int unsigned NMI_TYPE_NUM = 2;
endpackage

// File: rtl/nmi_edge_qual.sv
module nmi_edge_qual
    import irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HIGH    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    localparam int unsigned CNT_W = $clog2(MIN_HIGH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_HIGH - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    det_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic                   rise_d, rise_q;

    // synchroniser chain for the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DET_LOW;
            cnt_q   <= '0;
            rise_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rise_q  <= rise_d;
        end
    end

    // next state and rise pulse
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rise_d  = 1'b0;
        unique case (state_q)
            DET_LOW: begin
                if (level) begin
                    state_d = DET_ARM;
                    cnt_d   = CNT_W'(1);
                end
            end
            DET_ARM: begin
                if (!level) begin
                    state_d = DET_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DET_HIGH;
                    rise_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            DET_HIGH: begin
                if (!level) begin
                    state_d = DET_LOW;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = DET_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    assign rise = rise_q;

    AST_RISE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(level)); // R3
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R4
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic grant,
    input  logic handler_start,
    output logic pending
);
    nl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: merge edges in PEND, drop them in SERV before the handler starts
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NL_IDLE: if (rise)  state_d = NL_PEND;
            NL_PEND: if (grant) state_d = NL_SERV;
            NL_SERV: begin
                if (handler_start) state_d = rise ? NL_PEND : NL_IDLE;
            end
            default: state_d = NL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q == NL_PEND);
    end

    AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state_q == NL_PEND); // R5
    AST_SERV_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NL_SERV && !handler_start) |=> !pending); // R11
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int unsigned TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              nmi_pend,
    input  logic              intr_req,
    input  logic              int_enable,
    input  logic [TYPE_W-1:0] dev_type,
    input  logic              handler_start,
    output logic              grant_nmi,
    output logic              take,
    output logic              take_nmi,
    output logic [TYPE_W-1:0] take_type,
    output logic [TYPE_W+1:0] take_vec
);
    localparam logic [TYPE_W-1:0] NMI_TYPE = TYPE_W'(NMI_TYPE_NUM);

    ar_state_e         state_q, state_d;
    logic              fire_nmi, fire_intr;
    logic [TYPE_W-1:0] sel_type;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AR_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // fixed priority: NMI first, then the maskable request if enabled
    always_comb begin
        fire_nmi  = (state_q == AR_RUN) && boundary && nmi_pend;
        fire_intr = (state_q == AR_RUN) && boundary && !nmi_pend && intr_req && int_enable;
        sel_type  = fire_nmi ? NMI_TYPE : dev_type;
        state_d   = state_q;
        unique case (state_q)
            AR_RUN:  if (fire_nmi || fire_intr) state_d = AR_BUSY;
            AR_BUSY: if (handler_start)        state_d = AR_RUN;
            default: state_d = AR_RUN;
        endcase
    end

    assign grant_nmi = fire_nmi;

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take      <= 1'b0;
            take_nmi  <= 1'b0;
            take_type <= '0;
            take_vec  <= '0;
        end else begin
            take     <= fire_nmi || fire_intr;
            take_nmi <= fire_nmi;
            if (fire_nmi || fire_intr) begin
                take_type <= sel_type;
                take_vec  <= {sel_type, 2'b00};
            end
        end
    end

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take); // R9
    AST_INTR_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_nmi) |-> $past(int_enable) && $past(intr_req)); // R7
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_nmi) |-> !$past(nmi_pend)); // R6
    AST_NMI_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> take_type == NMI_TYPE); // R5
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> take_vec[1:0] == 2'b00); // R8
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HIGH    = 3,
    parameter int unsigned TYPE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              intr_req,
    input  logic              int_enable,
    input  logic              boundary,
    input  logic              handler_start,
    input  logic [TYPE_W-1:0] dev_type,
    output logic              take,
    output logic              take_nmi,
    output logic [TYPE_W-1:0] take_type,
    output logic [TYPE_W+1:0] take_vec,
    output logic              nmi_pending
);
    logic nmi_rise;
    logic grant_nmi;

    nmi_edge_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_HIGH   (MIN_HIGH)
    ) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (nmi_pin),
        .rise (nmi_rise)
    );

    nmi_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise         (nmi_rise),
        .grant        (grant_nmi),
        .handler_start(handler_start),
        .pending      (nmi_pending)
    );

    irq_arbiter #(
        .TYPE_W(TYPE_W)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary     (boundary),
        .nmi_pend     (nmi_pending),
        .intr_req     (intr_req),
        .int_enable   (int_enable),
        .dev_type     (dev_type),
        .handler_start(handler_start),
        .grant_nmi    (grant_nmi),
        .take         (take),
        .take_nmi     (take_nmi),
        .take_type    (take_type),
        .take_vec     (take_vec)
    );

    AST_PEND_CLEARS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_nmi) |-> !nmi_pending); // R10
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       intr_req = 1'b0;
    logic       int_enable = 1'b0;
    logic       boundary = 1'b0;
    logic       handler_start = 1'b0;
    logic [7:0] dev_type = '0;
    logic       take, take_nmi, nmi_pending;
    logic [7:0] take_type;
    logic [9:0] take_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_vector_unit u_irq_vector_unit (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .intr_req(intr_req),
        .int_enable(int_enable), .boundary(boundary), .handler_start(handler_start),
        .dev_type(dev_type), .take(take), .take_nmi(take_nmi), .take_type(take_type),
        .take_vec(take_vec), .nmi_pending(nmi_pending)
    );

    // {int_enable, intr_req, dev_type[7:0], expect_take, expect_vec[9:0]}
    localparam logic [20:0] VEC_TBL [6] = '{
        {1'b1, 1'b1, 8'h00, 1'b1, 10'h000},
        {1'b1, 1'b1, 8'h01, 1'b1, 10'h004},
        {1'b1, 1'b1, 8'hFF, 1'b1, 10'h3FC},
        {1'b1, 1'b1, 8'h21, 1'b1, 10'h084},
        {1'b0, 1'b1, 8'h33, 1'b0, 10'h000},
        {1'b1, 1'b0, 8'h44, 1'b0, 10'h000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic nmi_pulse(input int n);
        @(negedge clk) nmi_pin = 1'b1;
        repeat (n) @(negedge clk);
        nmi_pin = 1'b0;
    endtask

    // drive boundary for one cycle; on return the take cycle is visible
    task automatic strobe();
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
    endtask

    task automatic hstart();
        @(negedge clk) handler_start = 1'b1;
        @(negedge clk) handler_start = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(5);
        // R1 reset state
        check(take == 0 && take_nmi == 0, "R1 take idle", take, 0);
        check(nmi_pending == 0, "R1 pending idle", nmi_pending, 0);

        // R7 / R8 table of maskable requests
        for (int i = 0; i < 6; i++) begin
            int_enable = VEC_TBL[i][20];
            intr_req   = VEC_TBL[i][19];
            dev_type   = VEC_TBL[i][18:11];
            strobe();
            check(take == VEC_TBL[i][10], "R7 take", take, VEC_TBL[i][10]);
            if (VEC_TBL[i][10]) begin
                check(take_nmi == 0 && take_type == VEC_TBL[i][18:11], "R7 type", take_type, VEC_TBL[i][18:11]);
                check(take_vec == VEC_TBL[i][9:0], "R8 vector", take_vec, VEC_TBL[i][9:0]);
            end
            intr_req = 1'b0;
            hstart();
        end

        // R3 short pulses rejected
        nmi_pulse(1);
        idle(8);
        check(nmi_pending == 0, "R3 1-clock pulse", nmi_pending, 0);
        nmi_pulse(2);
        idle(8);
        check(nmi_pending == 0, "R3 2-clock pulse", nmi_pending, 0);

        // R2 qualified edge latched; R5 held until boundary, then type 2
        nmi_pulse(3);
        idle(6);
        check(nmi_pending == 1, "R2 3-clock pulse latched", nmi_pending, 1);
        idle(10);
        check(nmi_pending == 1 && take == 0, "R5 held without boundary", nmi_pending, 1);
        strobe();
        check(take == 1 && take_nmi == 1, "R5 nmi taken", {take, take_nmi}, 2'b11);
        check(take_type == 8'h02 && take_vec == 10'h008, "R5 type 2 vector", take_vec, 10'h008);
        @(negedge clk);
        check(take == 0, "R5 single pulse", take, 0);

        // R11 edge before handler start dropped
        nmi_pulse(4);
        idle(8);
        check(nmi_pending == 0, "R11 edge before start dropped", nmi_pending, 1'b0);
        // R9 boundary ignored while busy
        int_enable = 1'b1; intr_req = 1'b1; dev_type = 8'h40;
        strobe();
        check(take == 0, "R9 no take while busy", take, 0);
        intr_req = 1'b0;
        hstart();
        idle(4);
        check(nmi_pending == 0, "R11 no late request", nmi_pending, 0);
        nmi_pulse(3);
        idle(6);
        check(nmi_pending == 1, "R11 edge after start latched", nmi_pending, 1);
        strobe();
        hstart();

        // R6 simultaneous NMI and INTR
        intr_req = 1'b1; int_enable = 1'b1; dev_type = 8'h40;
        nmi_pulse(3);
        idle(6);
        strobe();
        check(take == 1 && take_nmi == 1 && take_type == 8'h02, "R6 nmi first", take_type, 8'h02);
        hstart();
        strobe();
        check(take == 1 && take_nmi == 0 && take_type == 8'h40, "R6 intr later", take_type, 8'h40);
        check(take_vec == 10'h100, "R8 vector 40h", take_vec, 10'h100);
        intr_req = 1'b0;
        hstart();

        // R10 two edges while pending merge
        nmi_pulse(3);
        idle(4);
        nmi_pulse(3);
        idle(6);
        strobe();
        check(take == 1 && take_nmi == 1, "R10 first take", take, 1);
        hstart();
        idle(2);
        check(nmi_pending == 0, "R10 merged", nmi_pending, 0);
        strobe();
        check(take == 0, "R10 no second take", take, 0);

        // R4 long level gives one request; falling edge none
        @(negedge clk) nmi_pin = 1'b1;
        idle(8);
        strobe();
        check(take == 1 && take_nmi == 1, "R4 held level taken", take, 1);
        hstart();
        idle(10);
        check(nmi_pending == 0, "R4 level no repeat", nmi_pending, 0);
        nmi_pin = 1'b0;
        idle(8);
        check(nmi_pending == 0, "R4 falling edge ignored", nmi_pending, 0);

        report();
    end
endmodule